// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block copies the whole contents of a small serial EEPROM, organised as 2^ADDR_W words of DATA_W bits, over a four-signal link: a chip select, a serial clock, a command line into the memory and a data line out of it. A one-cycle `start` pulse begins a run. For each address, from the lowest to the highest, the block selects the memory and shifts in a fresh read command. It checks that the memory drives the low marker bit, then clocks in the data word. It hands the word out with its address on a valid/ready port, then deselects the memory with one extra clock pulse.

All link timing comes from the system clock. Each serial clock pulse has a setup phase and a high phase, and each phase lasts `TICK_DIV` system cycles. With a 125 MHz system clock, the default of 250 gives about 2 µs per phase. A run always ends with a one-cycle `done` pulse. The `err` output is high in that cycle only when the memory failed to drive the marker bit low, which stops the run at that address.

Top module: `eewr_reader`

## Requirements
- R1: Each read command is 9 bits on `ee_do`, sent most significant bit first: the bits 1, 1, 0, then the word address from bit 5 down to bit 0. `ee_cs` is high for the whole command. `ee_do` is stable for at least `TICK_DIV` cycles before each rising edge of `ee_sck` and stays stable while `ee_sck` is high.
- R2: Every `ee_sck` pulse is high for exactly `TICK_DIV` system cycles.
- R3: `ee_di` is sampled in the last high cycle of the ninth command pulse. If it reads 1, the block lowers `ee_cs` and issues no further pulses or commands. It presents no word for that address and ends the run with `done` and `err` high.
- R4: After a good marker bit, 16 data bits are taken from `ee_di`, most significant bit first. Each bit is sampled in the last high cycle of its own `ee_sck` pulse.
- R5: While `word_valid` is high and `word_ready` is low, `word_data` and `word_index` hold their values and no `ee_sck` pulse starts. The word is accepted on a clock edge where both signals are high.
- R6: Once a word is accepted, `ee_cs` goes low and exactly one `ee_sck` pulse is issued with `ee_cs` low before the next command begins. This also happens after the last word.
- R7: Words are read and presented in ascending address order from 0 to 2^ADDR_W-1. After the deselect pulse of the last word, the run ends with `done` high and `err` low.
- R8: `done` is high for exactly one cycle at the end of every run, whether it succeeded or aborted. `err` is never high without `done`.
- R9: While `busy` is low, `ee_cs`, `ee_sck`, `ee_do` and `word_valid` are low. A `start` pulse while `busy` is high has no effect on the run in progress.
- R10: After synchronous reset, `busy`, `ee_cs`, `ee_sck`, `ee_do`, `word_valid`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read the whole memory |
| busy | output | 1 | High from the cycle after `start` up to and including the `done` cycle |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sck | output | 1 | Memory serial clock |
| ee_do | output | 1 | Command bits to the memory |
| ee_di | input | 1 | Data bits from the memory |
| word_valid | output | 1 | A received word is on offer |
| word_ready | input | 1 | Consumer accepts the offered word |
| word_data | output | DATA_W | Received word |
| word_index | output | ADDR_W | Address of the received word |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | With `done`: the run aborted on a bad marker bit |

## Verification
The bound checker watches the pin-level rules on every cycle:
- the exact length of each clock high time;
- command and select lines held still while the clock is high;
- output held still and no clock pulses while a word waits;
- quiet pins when idle;
- a single-cycle `done`, with `err` only alongside it.

Other behaviours show only in the bench's scenarios, where a behavioural memory model decodes each command and answers it, and a consumer stalls at random:
- the bit order and address of each command;
- that data is sampled in the right pulse;
- exactly one deselect pulse between words;
- ascending order across all 64 words;
- an abort at the first word and in the middle of a run;
- a stray `start` during a run being ignored.

// File: rtl/eewr_pkg.sv
// Shared types for the serial EEPROM word reader.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package eewr_pkg;

    // Top-level sequencer steps
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_DATA,
        SQ_PRESENT,
        SQ_DESEL,
        SQ_FINISH
    } seq_state_t;

    // Phases of one serial clock pulse
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH
    } pulse_phase_t;

    // Start bit followed by the two read opcode bits
    localparam logic [2:0] READ_PREFIX = 3'b110;

endpackage

// File: rtl/eewr_tick_timer.sv
// Phase timer: while run is high, pulses expire once every TICK_DIV cycles.
// Assumes TICK_DIV >= 1. The count clears whenever run is low.
module eewr_tick_timer #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(TICK_DIV - 1));

    // Count cycles inside the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/eewr_pulse_gen.sv
// Serial clock pulse generator. On go (while idle) it runs one setup phase
// with the clock low, then one high phase. Each phase lasts TICK_DIV cycles.
// fin is high in the last high cycle, which is also the sample point.
// Assumes go is only asserted while busy is low.
module eewr_pulse_gen #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic sck,
    output logic fin
);
    import eewr_pkg::*;

    pulse_phase_t phase;
    logic         expire;

    eewr_tick_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .expire (expire)
    );

    assign busy = (phase != PH_IDLE);
    assign sck  = (phase == PH_HIGH);
    assign fin  = (phase == PH_HIGH) && expire;

    // Step through setup and high phases of one pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:  if (go)     phase <= PH_SETUP;
                PH_SETUP: if (expire) phase <= PH_HIGH;
                PH_HIGH:  if (expire) phase <= PH_IDLE;
                default:              phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eewr_rx_shift.sv
// Serial-in receive register. It shifts bit_in in at the LSB on each strobe,
// so the first bit received ends up as the MSB.
module eewr_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] q
);
    // Collect one received bit per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[DATA_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/eewr_reader.sv
// Serial EEPROM word reader. On start it reads every word in ascending
// order, using one read command per word. It checks the marker bit, receives
// the data, offers it on a valid/ready port, then deselects with one pulse.
// Assumes DATA_W >= 2 and TICK_DIV >= 1. ee_di is synchronous to clk.
module eewr_reader #(
    parameter int TICK_DIV = 250,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              ee_cs,
    output logic              ee_sck,
    output logic              ee_do,
    input  logic              ee_di,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [DATA_W-1:0] word_data,
    output logic [ADDR_W-1:0] word_index,
    output logic              done,
    output logic              err
);
    import eewr_pkg::*;

    localparam int CMD_W     = 3 + ADDR_W;
    localparam int BIT_MAX   = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W     = $clog2(BIT_MAX);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_t        state;
    logic [CMD_W-1:0]  cmd_sr;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr;
    logic              cs_q;
    logic              err_q;
    logic              pulse_go;
    logic              pulse_busy;
    logic              pulse_fin;
    logic              rx_en;

    // Request a pulse whenever a pulsing step has the generator idle
    assign pulse_go = ((state == SQ_CMD) || (state == SQ_DATA) || (state == SQ_DESEL))
                      && !pulse_busy;
    assign rx_en    = (state == SQ_DATA) && pulse_fin;

    eewr_pulse_gen #(.TICK_DIV(TICK_DIV)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (pulse_go),
        .busy  (pulse_busy),
        .sck   (ee_sck),
        .fin   (pulse_fin)
    );

    eewr_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_en),
        .bit_in   (ee_di),
        .q        (word_data)
    );

    assign busy       = (state != SQ_IDLE);
    assign ee_cs      = cs_q;
    assign ee_do      = (state == SQ_CMD) && cmd_sr[CMD_W-1];
    assign word_valid = (state == SQ_PRESENT);
    assign word_index = addr;
    assign done       = (state == SQ_FINISH);
    assign err        = done && err_q;

    // Main sequencer: command, marker check, data, hand-off, deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            cmd_sr  <= '0;
            bit_cnt <= '0;
            addr    <= '0;
            cs_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state   <= SQ_CMD;
                        cmd_sr  <= {READ_PREFIX, {ADDR_W{1'b0}}};
                        bit_cnt <= '0;
                        addr    <= '0;
                        cs_q    <= 1'b1;
                        err_q   <= 1'b0;
                    end
                end
                SQ_CMD: begin
                    if (pulse_fin) begin
                        cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
                        if (bit_cnt == CNT_W'(CMD_W - 1)) begin
                            bit_cnt <= '0;
                            if (ee_di) begin
                                err_q <= 1'b1;
                                cs_q  <= 1'b0;
                                state <= SQ_FINISH;
                            end else begin
                                state <= SQ_DATA;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                SQ_DATA: begin
                    if (pulse_fin) begin
                        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                            bit_cnt <= '0;
                            state   <= SQ_PRESENT;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                end
                SQ_PRESENT: begin
                    if (word_ready) begin
                        cs_q  <= 1'b0;
                        state <= SQ_DESEL;
                    end
                end
                SQ_DESEL: begin
                    if (pulse_fin) begin
                        if (addr == LAST_ADDR) begin
                            state <= SQ_FINISH;
                        end else begin
                            addr   <= addr + ADDR_W'(1);
                            cmd_sr <= {READ_PREFIX, addr + ADDR_W'(1)};
                            cs_q   <= 1'b1;
                            state  <= SQ_CMD;
                        end
                    end
                end
                SQ_FINISH: begin
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eewr_reader_chk.sv
// Assertion checker for eewr_reader, attached by bind below.
// It observes ports only. It keeps its own count of clock high cycles.
module eewr_reader_chk #(
    parameter int TICK_DIV = 250,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ee_cs,
    input logic              ee_sck,
    input logic              ee_do,
    input logic              word_valid,
    input logic              word_ready,
    input logic [DATA_W-1:0] word_data,
    input logic [ADDR_W-1:0] word_index,
    input logic              done,
    input logic              err
);
    int hi_cnt;

    // Track consecutive cycles with the serial clock high
    always_ff @(posedge clk) begin
        if (!rst_n || !ee_sck) hi_cnt <= 0;
        else                   hi_cnt <= hi_cnt + 1;
    end

    // R2
    high_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sck |-> (hi_cnt < TICK_DIV));

    // R2
    high_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sck) |-> (hi_cnt == TICK_DIV));

    // R1
    do_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sck && $past(ee_sck)) |-> ($stable(ee_do) && $stable(ee_cs)));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=>
            (word_valid && $stable(word_data) && $stable(word_index)));

    // R5
    no_pulse_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !ee_sck);

    // R6
    cs_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ee_cs);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_sck && !ee_do && !word_valid));
endmodule

bind eewr_reader eewr_reader_chk #(
    .TICK_DIV (TICK_DIV),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ee_cs      (ee_cs),
    .ee_sck     (ee_sck),
    .ee_do      (ee_do),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .word_index (word_index),
    .done       (done),
    .err        (err)
);

// File: tb/tb_eewr_reader.sv
// Bench: a behavioural memory model answers each command, a random consumer
// stalls, and every pin is checked against the requirements each clock.
module tb_eewr_reader;
    localparam int TICK = 3;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int NW   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ee_di;
    logic          word_ready;
    logic          busy, ee_cs, ee_sck, ee_do, word_valid, done, err;
    logic [DW-1:0] word_data;
    logic [AW-1:0] word_index;

    eewr_reader #(.TICK_DIV(TICK), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_do(ee_do), .ee_di(ee_di),
        .word_valid(word_valid), .word_ready(word_ready),
        .word_data(word_data), .word_index(word_index),
        .done(done), .err(err)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_word(input int a);
        return DW'((a * 40503) ^ (a << 9) ^ 16'hA55A);
    endfunction

    // model and scoreboard state
    int            fail_at = -1;
    int            ready_mode = 0;
    int            m_cnt, m_addr, m_bit, desel, exp_idx, hi, st;
    logic [8:0]    m_cmd;
    logic [15:0]   lfsr;
    logic [DW-1:0] tmpw, data_q;
    logic [AW-1:0] idx_q;
    bit            sck_q, dout_q, done_q, stall_q, rise, done_seen, err_seen;

    // Memory model, consumer and per-cycle comparison, all away from posedge
    always @(negedge clk) begin
        if (!rst_n) begin
            ee_di = 1'b1; word_ready = 1'b0; lfsr = 16'hACE1;
            m_cnt = 0; m_addr = 0; m_bit = 0; desel = 0; hi = 0; st = 0;
            m_cmd = '0; sck_q = 0; dout_q = 0; done_q = 0; stall_q = 0;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            word_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] & lfsr[3]);
            // R9 idle pins
            if (!busy) chk(!ee_cs && !ee_sck && !ee_do && !word_valid, "R9 idle pins",
                           {ee_cs, ee_sck, ee_do, word_valid}, 0);
            // R8 done and err shape
            if (err) chk(done, "R8 err without done", done, 1);
            if (done && done_q) chk(0, "R8 done longer than one cycle", 1, 0);
            if (done) begin done_seen = 1; err_seen = err; end
            // R2 high time
            if (ee_sck) hi++;
            else if (sck_q) begin chk(hi == TICK, "R2 clock high cycles", hi, TICK); hi = 0; end
            rise = ee_sck && !sck_q;
            // R1 setup and hold of command bits
            if (ee_sck && sck_q) chk(ee_do == dout_q, "R1 do changed while clock high", ee_do, dout_q);
            if (rise && ee_cs && m_cnt < 9) chk(st >= TICK, "R1 do setup cycles", st, TICK);
            // R5 no pulse while a word is offered
            if (rise && word_valid) chk(0, "R5 pulse while word pending", 1, 0);
            // memory model
            if (!ee_cs) begin
                m_cnt = 0; ee_di = 1'b1;
                if (rise) desel++;
            end else if (rise) begin
                if (m_cnt < 9) begin
                    m_cmd = {m_cmd[7:0], ee_do};
                    m_cnt++;
                    if (m_cnt == 9) begin
                        chk(m_cmd[8:6] == 3'b110, "R1 command prefix", m_cmd[8:6], 6);
                        m_addr = int'(m_cmd[5:0]);
                        chk(m_addr == exp_idx, "R7 command address", m_addr, exp_idx);
                        if (exp_idx > 0) chk(desel == 1, "R6 deselect pulses between words", desel, 1);
                        desel = 0;
                        ee_di = (m_addr == fail_at);
                        m_bit = DW - 1;
                    end
                end else if (m_bit >= 0) begin
                    tmpw  = mem_word(m_addr);
                    ee_di = tmpw[m_bit];
                    m_bit--;
                end
            end
            // R5 held while stalled
            if (stall_q) chk(word_valid && word_data == data_q && word_index == idx_q,
                             "R5 word held while stalled", {word_valid, word_data}, {1'b1, data_q});
            if (word_valid && word_ready) begin
                chk(word_index == AW'(exp_idx), "R7 word index order", word_index, exp_idx);
                chk(word_data == mem_word(exp_idx), "R4 word data", word_data, mem_word(exp_idx));
                exp_idx++;
            end
            stall_q = word_valid && !word_ready;
            data_q  = word_data;
            idx_q   = word_index;
            st      = (ee_do == dout_q) ? st + 1 : 0;
            sck_q   = ee_sck; dout_q = ee_do; done_q = done;
        end
    end

    task automatic do_run(input int fa, input int rm, input bit poke,
                          input int exp_words, input bit exp_err);
        fail_at = fa; ready_mode = rm; exp_idx = 0; done_seen = 0; desel = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (500) @(negedge clk);
            chk(busy, "R9 busy mid run", busy, 1);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        if (exp_err) chk(exp_idx == exp_words, "R3 words before abort", exp_idx, exp_words);
        else         chk(exp_idx == exp_words, "R7 words in full run", exp_idx, exp_words);
        chk(err_seen == exp_err, "R8 err flag at done", err_seen, exp_err);
        if (!exp_err) chk(desel == 1, "R6 final deselect pulse", desel, 1);
        else          chk(desel == 0 && m_addr == fa, "R3 nothing after abort", m_addr, fa);
        repeat (3) @(negedge clk);
        chk(!busy && !ee_cs, "R3 idle after run", {busy, ee_cs}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({busy, ee_cs, ee_sck, ee_do, word_valid, done, err} == '0, "R10 reset state",
            {busy, ee_cs, ee_sck, ee_do, word_valid, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_run(-1, 0, 1'b0, NW, 1'b0);   // full run, consumer always ready
        do_run(-1, 1, 1'b1, NW, 1'b0);   // random stalls and a stray start
        do_run(5, 1, 1'b0, 5, 1'b1);     // abort in the middle
        do_run(0, 0, 1'b0, 0, 1'b1);     // abort on the first word
        do_run(-1, 0, 1'b0, NW, 1'b0);   // clean run after aborts
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule